// File: doc/BRIEF.md
# Coprocessor Context Restore Responder

This block is the coprocessor end of a context-restore exchange. A host drives a small register bus with three registers: control, restore and operand. A write to the restore register is a command. The block drops whatever it was doing and decodes the 16-bit format word. The next read of the restore register returns the verdict. A supported word reads back exactly as written. Any other word reads back as the fixed rejection value 0x0200.

When the host restores a non-empty context, it must then push that context as 32-bit operand-register writes. The block places these writes in consecutive slots of a small context memory and flags completion once the byte count given by the length field is reached. An empty/reset format clears the context at once. Writing 0x0001 to the control register abandons the exchange and clears the context. The bus is a plain one-access-per-cycle register port with no back-pressure: writes always take effect at the clock edge. Every read is answered exactly one cycle later with `rd_valid`. A context inspection port lets the surrounding logic read any memory slot combinationally.

Top module: `cp_restore_resp`

## Requirements
- R1: After reset `busy` and `restore_done` are 0, the restore register reads 0x0000, and every context slot reads 0.
- R2: The format word is bits [15:8] code and bits [7:0] length in bytes (bus bits 31:16 are ignored). Code 0x00 with length 0, and code `IDLE_CODE` (default 0x18) with length `IDLE_LEN` (default 16), are supported. A restore write of either reads back unchanged on the restore register.
- R3: Any other restore word, including a supported code with a different length, reads back as 0x0200 until the next restore write or abort.
- R4: After the idle format is accepted, `busy` is 1 and `restore_done` is 0. Operand writes (address 2) fill slots 0, 1, 2… in order. The write that brings the byte count to `IDLE_LEN` clears `busy` and sets `restore_done` at the same edge.
- R5: Once `restore_done` is set, further operand writes change no context slot.
- R6: Operand writes while no accepted restore is in progress have no effect on the context.
- R7: A restore write of the empty format zeroes every context slot, sets `restore_done` and leaves `busy` at 0.
- R8: A control write (address 0) of exactly 0x0001 clears `busy` and `restore_done`, zeroes the context, and makes the restore register read 0x0000.
- R9: A control write of any other value changes nothing.
- R10: A restore write during a transfer terminates it. The slot count restarts from 0, and the new word alone decides the state: accepted idle gives `busy`=1, a rejected word gives `busy`=0 and `restore_done`=0 with the context left as it was.
- R11: A read (`bus_rd`) sets `rd_valid` the next cycle with `rd_data` set as follows: restore register gives the reply zero-extended; control gives bit1=`restore_done`, bit0=`busy`; operand and address 3 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 restore, 2 operand |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read answer valid, one cycle after `bus_rd` |
| rd_data | output | 32 | Read answer data |
| busy | output | 1 | An accepted restore is waiting for operand data |
| restore_done | output | 1 | The context is complete |
| ctx_sel | input | $clog2(CTX_WORDS) | Context slot to inspect |
| ctx_word | output | 32 | Content of the selected slot |

## Verification
The bench sends a table of format words that tests each field separately: a supported code with the wrong length, a zero code with a non-zero length, a near-miss code, and upper bus bits set. A checker that compared only the code, or echoed the bus word, would return the wrong reply. Directed runs send one operand word past the length, send operand data before any restore and after an abort, restart a half-finished transfer with a second restore write, and write a non-abort control value. These runs catch a counter that keeps writing, an abort that leaves stale slots or a stale reply, and a terminate that does not rewind the slot index.

// File: rtl/cp_restore_pkg.sv
package cp_restore_pkg;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_RESTORE = 2'd1,
    REG_OPERAND = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    FMT_EMPTY,
    FMT_IDLE,
    FMT_BAD
  } fmt_kind_e;

  typedef enum logic [2:0] {
    SNK_NONE,
    SNK_START,
    SNK_EMPTY,
    SNK_STOP,
    SNK_KILL
  } sink_cmd_e;

  localparam logic [15:0] BAD_FMT_REPLY = 16'h0200;
  localparam logic [31:0] ABORT_VALUE   = 32'h0000_0001;

endpackage

// File: rtl/fmt_check.sv
module fmt_check
  import cp_restore_pkg::*;
#(
  parameter logic [7:0] IDLE_CODE = 8'h18,
  parameter logic [7:0] IDLE_LEN  = 8'd16
) (
  input  logic [15:0] fmt_word,
  output fmt_kind_e   kind
);

  logic [7:0] code;
  logic [7:0] len;

  assign code = fmt_word[15:8];
  assign len  = fmt_word[7:0];

  always_comb begin
    if (code == 8'h00 && len == 8'h00)
      kind = FMT_EMPTY;
    else if (code == IDLE_CODE && len == IDLE_LEN)
      kind = FMT_IDLE;
    else
      kind = FMT_BAD;
  end

endmodule

// File: rtl/op_sink.sv
module op_sink
  import cp_restore_pkg::*;
#(
  parameter int CTX_WORDS  = 8,
  parameter int NEED_WORDS = 4,
  localparam int AW = $clog2(CTX_WORDS),
  localparam int CW = $clog2(CTX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sink_cmd_e     cmd,
  input  logic          op_wr,
  input  logic [31:0]   op_data,
  input  logic [AW-1:0] sel,
  output logic          active,
  output logic          done,
  output logic [31:0]   sel_word
);

  localparam logic [CW-1:0] LAST = CW'(NEED_WORDS - 1);

  logic [31:0]   mem [CTX_WORDS];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
      for (int i = 0; i < CTX_WORDS; i++) mem[i] <= '0;
    end else begin
      case (cmd)
        SNK_START: begin
          cnt    <= '0;
          active <= 1'b1;
          done   <= 1'b0;
        end
        SNK_EMPTY: begin
          cnt    <= '0;
          active <= 1'b0;
          done   <= 1'b1;
          for (int i = 0; i < CTX_WORDS; i++) mem[i] <= '0;
        end
        SNK_STOP: begin
          cnt    <= '0;
          active <= 1'b0;
          done   <= 1'b0;
        end
        SNK_KILL: begin
          cnt    <= '0;
          active <= 1'b0;
          done   <= 1'b0;
          for (int i = 0; i < CTX_WORDS; i++) mem[i] <= '0;
        end
        default: begin
          if (active && op_wr) begin
            mem[cnt[AW-1:0]] <= op_data;
            cnt              <= cnt + 1'b1;
            if (cnt == LAST) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign sel_word = mem[sel];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= LAST)); // R4

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && done)); // R4

  AST_FILL_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op_wr && cmd == SNK_NONE && cnt == LAST) |=> (done && !active)); // R4

  AST_IDLE_OPERAND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && op_wr && cmd == SNK_NONE) |=> ($stable(cnt) && !active)); // R6

endmodule

// File: rtl/cp_restore_resp.sv
module cp_restore_resp
  import cp_restore_pkg::*;
#(
  parameter int         CTX_WORDS = 8,
  parameter logic [7:0] IDLE_CODE = 8'h18,
  parameter logic [7:0] IDLE_LEN  = 8'd16,
  localparam int        AW         = $clog2(CTX_WORDS),
  localparam int        NEED_WORDS = int'(IDLE_LEN) / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          busy,
  output logic          restore_done,
  input  logic [AW-1:0] ctx_sel,
  output logic [31:0]   ctx_word
);

  fmt_kind_e   kind;
  sink_cmd_e   cmd;
  logic [15:0] reply;
  logic        abort_wr;
  logic        restore_wr;
  logic        operand_wr;

  assign abort_wr   = bus_wr && bus_addr == REG_CTRL && bus_wdata == ABORT_VALUE;
  assign restore_wr = bus_wr && bus_addr == REG_RESTORE;
  assign operand_wr = bus_wr && bus_addr == REG_OPERAND;

  fmt_check #(
    .IDLE_CODE (IDLE_CODE),
    .IDLE_LEN  (IDLE_LEN)
  ) u_fmt (
    .fmt_word (bus_wdata[15:0]),
    .kind     (kind)
  );

  always_comb begin
    cmd = SNK_NONE;
    if (abort_wr)
      cmd = SNK_KILL;
    else if (restore_wr) begin
      case (kind)
        FMT_EMPTY: cmd = SNK_EMPTY;
        FMT_IDLE:  cmd = SNK_START;
        default:   cmd = SNK_STOP;
      endcase
    end
  end

  op_sink #(
    .CTX_WORDS  (CTX_WORDS),
    .NEED_WORDS (NEED_WORDS)
  ) u_sink (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .op_wr    (operand_wr),
    .op_data  (bus_wdata),
    .sel      (ctx_sel),
    .active   (busy),
    .done     (restore_done),
    .sel_word (ctx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      reply <= '0;
    else if (abort_wr)
      reply <= '0;
    else if (restore_wr)
      reply <= (kind == FMT_BAD) ? BAD_FMT_REPLY : bus_wdata[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          REG_RESTORE: rd_data <= {16'h0000, reply};
          REG_CTRL:    rd_data <= {30'd0, restore_done, busy};
          default:     rd_data <= '0;
        endcase
      end
    end
  end

  AST_REPLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    restore_wr |=> (reply == BAD_FMT_REPLY || reply == $past(bus_wdata[15:0]))); // R3

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!busy && !restore_done && reply == 16'h0000)); // R8

  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid); // R11

endmodule

// File: tb/cp_restore_resp_test.sv
module cp_restore_resp_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        busy;
  logic        restore_done;
  logic [2:0]  ctx_sel = '0;
  logic [31:0] ctx_word;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cp_restore_resp uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .busy         (busy),
    .restore_done (restore_done),
    .ctx_sel      (ctx_sel),
    .ctx_word     (ctx_word)
  );

  // {written word, expected reply}
  localparam logic [63:0] VEC [0:7] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_1810, 32'h0000_1810},
    {32'h0000_1808, 32'h0000_0200},
    {32'h0000_0204, 32'h0000_0200},
    {32'h0000_0004, 32'h0000_0200},
    {32'h0000_1910, 32'h0000_0200},
    {32'h0000_0200, 32'h0000_0200},
    {32'hABCD_1810, 32'h0000_1810}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic ctx(input int i, output logic [31:0] d);
    ctx_sel = 3'(i);
    #0.1;
    d = ctx_word;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, restore_done}, 32'd0);
    rd(2'd1, d, v);
    chk("R1 restore read", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      ctx(i, d);
      chk("R1 context zero", d, 32'h0);
    end

    // R6 operand before any restore
    wr(2'd2, 32'h1111_1111);
    ctx(0, d);
    chk("R6 operand ignored idle", d, 32'h0);

    // R2 R3 format table
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, VEC[k][63:32]);
      rd(2'd1, d, v);
      chk("R2/R3 reply", d, VEC[k][31:0]);
      chk("R11 rd_valid", {31'd0, v}, 32'd1);
      chk("R4 busy after eval", {31'd0, busy}, {31'd0, VEC[k][31:0] == 32'h1810});
      chk("R7 done after eval", {31'd0, restore_done}, {31'd0, VEC[k][31:0] == 32'h0000});
    end

    // R4 full transfer (last vector accepted idle)
    for (int i = 0; i < 4; i++) begin
      wr(2'd2, 32'hA000_0000 + 32'(i));
      chk("R4 busy during fill", {31'd0, busy}, {31'd0, i != 3});
      chk("R4 done at fill end", {31'd0, restore_done}, {31'd0, i == 3});
    end
    for (int i = 0; i < 4; i++) begin
      ctx(i, d);
      chk("R4 slot contents", d, 32'hA000_0000 + 32'(i));
    end
    rd(2'd0, d, v);
    chk("R11 control read", d, 32'h2);
    rd(2'd2, d, v);
    chk("R11 operand read zero", d, 32'h0);

    // R5 extra operand after done
    wr(2'd2, 32'hDEAD_BEEF);
    ctx(0, d);
    chk("R5 slot0 unchanged", d, 32'hA000_0000);
    ctx(4, d);
    chk("R5 slot4 untouched", d, 32'h0);

    // R9 non-abort control write
    wr(2'd0, 32'h0000_0002);
    chk("R9 done kept", {31'd0, restore_done}, 32'd1);
    rd(2'd1, d, v);
    chk("R9 reply kept", d, 32'h1810);

    // R10 terminate mid-transfer, restart
    wr(2'd1, 32'h1810);
    wr(2'd2, 32'hB000_0000);
    wr(2'd2, 32'hB000_0001);
    wr(2'd1, 32'h1810);
    chk("R10 busy after restart", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 4; i++) wr(2'd2, 32'hC000_0000 + 32'(i));
    ctx(0, d);
    chk("R10 slot0 restarted", d, 32'hC000_0000);
    ctx(3, d);
    chk("R10 slot3", d, 32'hC000_0003);
    chk("R10 done", {31'd0, restore_done}, 32'd1);

    // R10 rejected word during transfer
    wr(2'd1, 32'h1810);
    wr(2'd2, 32'hE000_0000);
    wr(2'd1, 32'h1234);
    chk("R10 busy cleared", {31'd0, busy}, 32'd0);
    chk("R10 done cleared", {31'd0, restore_done}, 32'd0);
    wr(2'd2, 32'hF000_0000);
    ctx(0, d);
    chk("R10 context kept", d, 32'hE000_0000);
    ctx(1, d);
    chk("R6 operand after reject", d, 32'hC000_0001);

    // R8 abort mid-transfer
    wr(2'd1, 32'h1810);
    wr(2'd2, 32'hD000_0000);
    wr(2'd0, 32'h0000_0001);
    chk("R8 busy", {31'd0, busy}, 32'd0);
    chk("R8 done", {31'd0, restore_done}, 32'd0);
    ctx(0, d);
    chk("R8 context cleared", d, 32'h0);
    rd(2'd1, d, v);
    chk("R8 reply cleared", d, 32'h0);
    wr(2'd2, 32'h7777_7777);
    ctx(0, d);
    chk("R6 operand after abort", d, 32'h0);

    // R7 empty format zeroes context
    wr(2'd1, 32'h1810);
    for (int i = 0; i < 4; i++) wr(2'd2, 32'h5000_0000 + 32'(i));
    wr(2'd1, 32'h0000);
    for (int i = 0; i < 4; i++) begin
      ctx(i, d);
      chk("R7 context zeroed", d, 32'h0);
    end
    chk("R7 done", {31'd0, restore_done}, 32'd1);
    chk("R7 busy", {31'd0, busy}, 32'd0);

    finish_run();
  end

endmodule